// File: doc/BRIEF.md
# Dual Snapshot Counter with Byte-Wide Readout

Two free-running up counters, each on its own rising-edge clock, are copied into a pair of holding registers on the rising edge of a third clock. Because both holding registers load on that one edge, the two counts are frozen at a common instant. Software or a host can then read them at leisure without the live counters changing under it.

The holding registers are read through a shared byte-wide bus. Four active-low selects pick the low or high byte of either holding register. When no select is low, the bus is released to high impedance. A companion output tells a pad or bus keeper whether the bus is being driven.

Counter A raises a carry flag while it sits at its all-ones value. Counter B counts only when its enable input is high. Tying the two counter clocks together and feeding the carry into counter B's enable turns the pair into one counter twice as wide. Each counter has its own active-low synchronous clear.

The readout is a plain select-and-drive bus with no valid/ready handshake. The selects take effect combinationally, so there is no back-pressure. Data is stable for as long as no snapshot edge occurs.

Top module: `dual_snap_counter`

## Requirements
- R1: On a rising `clk_a` edge with `clr_a_n` low, counter A becomes zero. On a rising `clk_b` edge with `clr_b_n` low, counter B becomes zero, whatever `en_b` is.
- R2: On every rising `clk_a` edge with `clr_a_n` high, counter A increments by one modulo 2^(2·BUS_W).
- R3: On a rising `clk_b` edge with `clr_b_n` high, counter B increments by one if `en_b` is high and keeps its value if `en_b` is low.
- R4: `carry_a` is high exactly while counter A holds all ones; the next `clk_a` edge without a clear wraps it to zero.
- R5: On a rising `snap_clk` edge, both holding registers load the current counter values. When a counter clock rises in the same instant, the value from before that increment is captured.
- R6: Select encoding: `sel_al_n` picks bits [BUS_W-1:0] of holding A, `sel_ah_n` bits [2·BUS_W-1:BUS_W] of holding A, `sel_bl_n` the low byte of holding B, and `sel_bh_n` the high byte of holding B, each when low.
- R7: When several selects are low, the winner is, from highest priority down: A-low, A-high, B-low, B-high.
- R8: With all four selects high, `q_oe` is 0 and `q_bus` is high impedance. With any select low, `q_oe` is 1.
- R9: With `clk_b` tied to `clk_a` and `en_b` driven from `carry_a`, the pair counts as one counter of 4·BUS_W bits, with A as the low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Counter A clock, rising edge |
| clk_b | input | 1 | Counter B clock, rising edge |
| snap_clk | input | 1 | Holding-register load clock, rising edge |
| clr_a_n | input | 1 | Synchronous clear of counter A, active low |
| clr_b_n | input | 1 | Synchronous clear of counter B, active low |
| en_b | input | 1 | Count enable of counter B |
| carry_a | output | 1 | High while counter A is all ones |
| sel_al_n | input | 1 | Select low byte of holding A, active low |
| sel_ah_n | input | 1 | Select high byte of holding A, active low |
| sel_bl_n | input | 1 | Select low byte of holding B, active low |
| sel_bh_n | input | 1 | Select high byte of holding B, active low |
| q_oe | output | 1 | High while the bus is driven |
| q_bus | output | BUS_W | Selected byte, high impedance when `q_oe` is 0 |

## Verification
The bench builds the block with BUS_W = 4, so each counter is 8 bits wide. At that width, counter A wraps and raises its carry within a few hundred edges. The cascaded mode can then be followed through several carries into counter B inside the run. Every width-dependent path is the same as at the default of 8; only the wrap distance shrinks.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_AL   = 3'd1,
    SRC_AH   = 3'd2,
    SRC_BL   = 3'd3,
    SRC_BH   = 3'd4
  } byte_src_e;
endpackage

// File: rtl/dsc_counter.sv
module dsc_counter #(
  parameter int  W     = 16,
  parameter bit  GATED = 1'b0
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic         en,
  output logic [W-1:0] cnt,
  output logic         at_max
);
  logic step;

  generate
    if (GATED) begin : g_gated
      assign step = en;
    end else begin : g_free
      assign step = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!clr_n)    cnt <= '0;
    else if (step) cnt <= cnt + 1'b1;
  end

  assign at_max = &cnt;
endmodule

// File: rtl/dsc_snapshot.sv
module dsc_snapshot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic [W-1:0] live_a,
  input  logic [W-1:0] live_b,
  output logic [W-1:0] held_a,
  output logic [W-1:0] held_b
);
  always_ff @(posedge clk) begin
    held_a <= live_a;
    held_b <= live_b;
  end
endmodule

// File: rtl/dsc_byte_sel.sv
module dsc_byte_sel
  import dsc_pkg::*;
#(
  parameter int BUS_W = 8,
  localparam int WW   = 2 * BUS_W
) (
  input  logic [3:0]       sel_n,   // {bh, bl, ah, al}
  input  logic [WW-1:0]    word_a,
  input  logic [WW-1:0]    word_b,
  output logic [BUS_W-1:0] byte_out,
  output logic             drive
);
  byte_src_e src;
  logic [BUS_W-1:0] lanes [4];

  genvar gi;
  generate
    for (gi = 0; gi < 2; gi++) begin : g_lane
      assign lanes[gi]     = word_a[gi*BUS_W +: BUS_W];
      assign lanes[gi + 2] = word_b[gi*BUS_W +: BUS_W];
    end
  endgenerate

  always_comb begin
    if      (!sel_n[0]) src = SRC_AL;
    else if (!sel_n[1]) src = SRC_AH;
    else if (!sel_n[2]) src = SRC_BL;
    else if (!sel_n[3]) src = SRC_BH;
    else                src = SRC_NONE;
  end

  always_comb begin
    unique case (src)
      SRC_AL:  byte_out = lanes[0];
      SRC_AH:  byte_out = lanes[1];
      SRC_BL:  byte_out = lanes[2];
      SRC_BH:  byte_out = lanes[3];
      default: byte_out = '0;
    endcase
  end

  assign drive = (src != SRC_NONE);
endmodule

// File: rtl/dual_snap_counter.sv
module dual_snap_counter #(
  parameter int BUS_W = 8,
  localparam int CW   = 2 * BUS_W
) (
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             snap_clk,
  input  logic             clr_a_n,
  input  logic             clr_b_n,
  input  logic             en_b,
  output logic             carry_a,
  input  logic             sel_al_n,
  input  logic             sel_ah_n,
  input  logic             sel_bl_n,
  input  logic             sel_bh_n,
  output logic             q_oe,
  output logic [BUS_W-1:0] q_bus
);
  logic [CW-1:0]    cnt_a, cnt_b, held_a, held_b;
  logic [BUS_W-1:0] byte_val;
  logic             b_max_unused;

  dsc_counter #(.W(CW), .GATED(1'b0)) u_cnt_a (
    .clk(clk_a), .clr_n(clr_a_n), .en(1'b1), .cnt(cnt_a), .at_max(carry_a)
  );

  dsc_counter #(.W(CW), .GATED(1'b1)) u_cnt_b (
    .clk(clk_b), .clr_n(clr_b_n), .en(en_b), .cnt(cnt_b), .at_max(b_max_unused)
  );

  dsc_snapshot #(.W(CW)) u_snap (
    .clk(snap_clk), .live_a(cnt_a), .live_b(cnt_b),
    .held_a(held_a), .held_b(held_b)
  );

  dsc_byte_sel #(.BUS_W(BUS_W)) u_sel (
    .sel_n({sel_bh_n, sel_bl_n, sel_ah_n, sel_al_n}),
    .word_a(held_a), .word_b(held_b),
    .byte_out(byte_val), .drive(q_oe)
  );

  assign q_bus = q_oe ? byte_val : {BUS_W{1'bz}};
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int BUS_W = 8,
  localparam int CW   = 2 * BUS_W
) (
  input logic          clk_a,
  input logic          clk_b,
  input logic          snap_clk,
  input logic          clr_a_n,
  input logic          clr_b_n,
  input logic          en_b,
  input logic          carry_a,
  input logic          sel_al_n,
  input logic          sel_ah_n,
  input logic          sel_bl_n,
  input logic          sel_bh_n,
  input logic          q_oe,
  input logic [CW-1:0] cnt_a,
  input logic [CW-1:0] cnt_b,
  input logic [CW-1:0] held_a
);
  // R1
  clr_a_zero_chk: assert property (@(posedge clk_a) disable iff (clr_a_n === 1'bx)
    !clr_a_n |=> cnt_a == '0);

  // R1
  clr_b_zero_chk: assert property (@(posedge clk_b) disable iff (clr_b_n === 1'bx)
    !clr_b_n |=> cnt_b == '0);

  // R3
  b_hold_chk: assert property (@(posedge clk_b) disable iff (!clr_b_n)
    !en_b |=> $stable(cnt_b));

  // R4
  carry_wrap_chk: assert property (@(posedge clk_a) disable iff (!clr_a_n)
    carry_a |=> cnt_a == '0);

  // R5
  snap_load_chk: assert property (@(posedge snap_clk) disable iff (!clr_a_n)
    1'b1 |=> held_a == $past(cnt_a));

  // R8
  idle_bus_chk: assert property (@(posedge snap_clk)
    (sel_al_n && sel_ah_n && sel_bl_n && sel_bh_n) |-> !q_oe);
endmodule

bind dual_snap_counter dsc_checker #(.BUS_W(BUS_W)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .snap_clk(snap_clk),
  .clr_a_n(clr_a_n), .clr_b_n(clr_b_n), .en_b(en_b), .carry_a(carry_a),
  .sel_al_n(sel_al_n), .sel_ah_n(sel_ah_n), .sel_bl_n(sel_bl_n), .sel_bh_n(sel_bh_n),
  .q_oe(q_oe), .cnt_a(cnt_a), .cnt_b(cnt_b), .held_a(held_a)
);

// File: tb/tb_dual_snap_counter.sv
module tb_dual_snap_counter;
  localparam int BW     = 4;
  localparam int CW     = 2 * BW;
  localparam int MASK   = (1 << CW) - 1;
  localparam int T_CLK  = 10;

  logic clk_a = 0, clk_b = 0, snap_clk = 0;
  logic clr_a_n = 0, clr_b_n = 0, en_b_drv = 0, cascade = 0;
  logic sel_al_n = 1, sel_ah_n = 1, sel_bl_n = 1, sel_bh_n = 1;
  logic carry_a, q_oe, en_b;
  logic [BW-1:0] q_bus;

  int checks = 0, fails = 0;
  int ma = 0, mb = 0, sa = 0, sb = 0;
  bit done = 0;

  assign en_b = cascade ? carry_a : en_b_drv;

  dual_snap_counter #(.BUS_W(BW)) dut (
    .clk_a(clk_a), .clk_b(clk_b), .snap_clk(snap_clk),
    .clr_a_n(clr_a_n), .clr_b_n(clr_b_n), .en_b(en_b), .carry_a(carry_a),
    .sel_al_n(sel_al_n), .sel_ah_n(sel_ah_n), .sel_bl_n(sel_bl_n), .sel_bh_n(sel_bh_n),
    .q_oe(q_oe), .q_bus(q_bus)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference: expected byte for current selects
  task automatic check_bus(input string req);
    int exp_oe, exp_v;
    exp_oe = 1;
    if      (!sel_al_n) exp_v = sa & ((1 << BW) - 1);
    else if (!sel_ah_n) exp_v = (sa >> BW) & ((1 << BW) - 1);
    else if (!sel_bl_n) exp_v = sb & ((1 << BW) - 1);
    else if (!sel_bh_n) exp_v = (sb >> BW) & ((1 << BW) - 1);
    else begin exp_oe = 0; exp_v = 0; end
    chk({req, " oe"}, int'(q_oe), exp_oe);
    if (exp_oe == 1) chk({req, " bus"}, int'(q_bus), exp_v);
  endtask

  // one edge on any subset of the clocks, model updated, compared after
  task automatic step(input bit ea, input bit eb, input bit es);
    int old_a;
    bit eff_en;
    old_a  = ma;
    eff_en = cascade ? (old_a == MASK) : en_b_drv;
    #(T_CLK/2);
    clk_a = ea; clk_b = eb; snap_clk = es;
    if (es) begin sa = ma; sb = mb; end
    if (ea) ma = !clr_a_n ? 0 : ((ma + 1) & MASK);
    if (eb) mb = !clr_b_n ? 0 : (eff_en ? ((mb + 1) & MASK) : mb);
    #(T_CLK/2);
    clk_a = 0; clk_b = 0; snap_clk = 0;
    chk("R4 carry", int'(carry_a), int'(ma == MASK));
    check_bus("R6 per-step");
  endtask

  task automatic snap_and_read(input string req);
    step(0, 0, 1);
    sel_al_n = 0; #1; check_bus({req, " A-lo"}); sel_al_n = 1;
    sel_ah_n = 0; #1; check_bus({req, " A-hi"}); sel_ah_n = 1;
    sel_bl_n = 0; #1; check_bus({req, " B-lo"}); sel_bl_n = 1;
    sel_bh_n = 0; #1; check_bus({req, " B-hi"}); sel_bh_n = 1;
  endtask

  initial begin
    #(T_CLK * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1 clear both counters
    step(1, 1, 0);
    snap_and_read("R1 reset");
    chk("R8 idle oe", int'(q_oe), 0);
    clr_a_n = 1; clr_b_n = 1;

    // R2 / R3 with enable low then high
    for (int i = 0; i < 5; i++) step(1, 1, 0);
    snap_and_read("R2 R3 hold");
    en_b_drv = 1;
    for (int i = 0; i < 23; i++) step(1, (i % 2) == 0, 0);
    snap_and_read("R2 R3 count");

    // R5 same-edge capture of pre-increment value
    step(1, 1, 1);
    snap_and_read("R5 same-edge");
    step(1, 1, 1);
    sel_ah_n = 0; #1; check_bus("R5 coincident hi"); sel_ah_n = 1;

    // R7 priority with several selects low
    sel_bh_n = 0; sel_bl_n = 0; #1; check_bus("R7 BL over BH");
    sel_ah_n = 0; #1; check_bus("R7 AH over BL");
    sel_al_n = 0; #1; check_bus("R7 AL over all");
    sel_al_n = 1; sel_ah_n = 1; sel_bl_n = 1; sel_bh_n = 1; #1;
    check_bus("R8 released");

    // R4 run A through wrap
    for (int i = 0; i < 300; i++) step(1, 0, 0);
    snap_and_read("R4 after wrap");

    // R1 clear of B while enabled
    clr_b_n = 0; step(0, 1, 0); clr_b_n = 1;
    snap_and_read("R1 B clear");

    // R9 cascade
    clr_a_n = 0; clr_b_n = 0; step(1, 1, 0); clr_a_n = 1; clr_b_n = 1;
    cascade = 1;
    for (int i = 0; i < 700; i++) begin
      step(1, 1, (i % 97) == 0);
      if ((i % 97) == 0) begin
        sel_bl_n = 0; #1; check_bus("R9 cascade hi half"); sel_bl_n = 1;
      end
    end
    snap_and_read("R9 final");
    chk("R9 combined", (mb << CW) | ma, 700);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule